// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch and decode logic of a small 8-bit processor core. It decides when a pending interrupt is taken and then runs a fixed-length entry sequence. The entry sequence saves the 22-bit return address into a byte-wide stack memory and redirects fetch to the vector of the chosen request. A return strobe starts the reverse sequence. That sequence reads the three saved bytes, reloads the program counter, moves the stack pointer back and turns the global interrupt enable on again. While a sequence runs, `busy` is high and the core holds its fetch.

The core reports each finished instruction with `insn_boundary`. Its interrupt-enable, interrupt-disable, return and sleep strobes count only in a cycle where that pin is high. A multi-cycle instruction therefore always completes before a request is considered. During sleep the core issues no boundaries. Instead, `wake` marks the cycle in which an interrupt may be taken, and that entry costs five extra cycles.

The block has no valid/ready handshake. Its timing is exact to the cycle, so the stack port works without back-pressure. A write happens in the cycle its strobe is high. Read data must be presented on `stk_rdata` in the cycle after `stk_re`.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, `gie` is 0, `sleeping` is 0, `busy` is 0, `sp` equals `SP_RESET`, and `irq_ack`, `stk_we`, `stk_re` and `pc_load` are all 0.
- R2: The block accepts an interrupt in a cycle that meets all of these conditions: the block is idle and awake, `insn_boundary` is 1, `gie` is 1, the enable-delay is clear, none of the enable, disable or return strobes is high, and at least one request is set. In that same cycle `irq_ack` is one-hot on the lowest-numbered set request. A request raised while `insn_boundary` is 0 waits for the next boundary.
- R3: Call the acceptance cycle cycle 0. In entry cycles 1, 2 and 3 the block writes PC[7:0] at `sp`, then PC[15:8] at `sp`-1, then {2'b00, PC[21:16]} at `sp`-2. `sp` drops by one after each write and ends 3 lower.
- R4: `pc_load` is high in the fifth cycle after acceptance, with `pc_load_val` = request index × 2. `busy` is high in cycles 1 to 5. `gie` is 0 from cycle 1.
- R5: A sleep strobe at a boundary where no interrupt is accepted sets `sleeping`. While sleeping, the block accepts only in a cycle where `wake`, `gie` and a request are all high. `sleeping` then clears, the three writes fall in cycles 6 to 8, and `pc_load` is high in cycle 10.
- R6: A return strobe at a boundary starts a 5-cycle return. In cycles 1, 2 and 3 the block reads `sp`+1, and `sp` rises by one after each read. The three bytes read, in that order, are PC[21:16], PC[15:8] and PC[7:0]. In cycle 5 `pc_load` reloads the assembled PC. `gie` is 1 from cycle 6.
- R7: After an enable strobe, or after a return completes, the next boundary never accepts an interrupt. A sleep at that next boundary is therefore entered before any pending request is served.
- R8: A disable strobe blocks acceptance at its own boundary, and `gie` is 0 from the next cycle.
- R9: Boundaries and strobes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NUM_IRQ | Pending request levels; a lower bit has higher priority |
| insn_boundary | input | 1 | The current instruction completes this cycle |
| sei_strobe | input | 1 | Enable-interrupts instruction, sampled at a boundary |
| cli_strobe | input | 1 | Disable-interrupts instruction, sampled at a boundary |
| reti_strobe | input | 1 | Return-from-interrupt instruction, sampled at a boundary |
| sleep_strobe | input | 1 | Sleep instruction, sampled at a boundary |
| wake | input | 1 | Wake-up start-up done; an interrupt may be taken from sleep |
| pc_cur | input | PC_W | Return address to save on acceptance |
| irq_ack | output | NUM_IRQ | One-hot acknowledge in the acceptance cycle |
| gie | output | 1 | Global interrupt enable |
| sleeping | output | 1 | Core is in sleep |
| busy | output | 1 | Entry or return sequence running; hold fetch |
| sp | output | SP_W | Stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe; data is due in the next cycle |
| stk_addr | output | SP_W | Stack address |
| stk_wdata | output | 8 | Stack write byte |
| stk_rdata | input | 8 | Stack read byte |
| pc_load | output | 1 | Load the program counter |
| pc_load_val | output | PC_W | Vector or restored return address |

## Verification
The hardest state to reach from the ports is a request held back by the enable-delay while a sleep instruction sits at the blocked boundary. The core must go to sleep with the request still pending and take it only on a later wake, with the ten-cycle entry. The stimulus raises a request while `gie` is off, then issues the enable strobe immediately followed by a sleep strobe. The bench model then has to predict no acknowledge, the `sleeping` flag, and an acceptance exactly in the wake cycle. Strobes driven during a running entry check that the block ignores them while busy.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WAKE, SQ_PUSH, SQ_POP} seq_state_e;
  localparam int SEQ_LEN  = 5;
  localparam int WAKE_LEN = 5;
  localparam int STEP_W   = 3;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_chain
    assign seen[gi+1]  = seen[gi] | req[gi];
    assign onehot[gi]  = req[gi] & ~seen[gi];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (onehot[i]) idx = idx | IW'(i);
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic sei_s,
  input  logic cli_s,
  input  logic reti_s,
  input  logic sleep_s,
  input  logic wake,
  input  logic any_pend,
  input  logic idle,
  input  logic ret_done,
  output logic gie,
  output logic sleeping,
  output logic accept,
  output logic accept_asleep,
  output logic start_ret
);
  logic shadow;
  logic q_evt, q_sei, q_cli, q_sleep, acc_awake;

  assign q_evt   = idle & ~sleeping & boundary;
  assign q_sei   = q_evt & sei_s;
  assign q_cli   = q_evt & cli_s;
  assign q_sleep = q_evt & sleep_s;
  assign start_ret = q_evt & reti_s;

  assign acc_awake     = q_evt & gie & ~shadow & ~sei_s & ~cli_s & ~reti_s & any_pend;
  assign accept_asleep = idle & sleeping & wake & gie & any_pend;
  assign accept        = acc_awake | accept_asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      shadow   <= 1'b0;
      sleeping <= 1'b0;
    end else begin
      if (accept)        gie <= 1'b0;
      else if (ret_done) gie <= 1'b1;
      else if (q_cli)    gie <= 1'b0;
      else if (q_sei)    gie <= 1'b1;

      if (ret_done)      shadow <= 1'b1;
      else if (q_sei)    shadow <= 1'b1;
      else if (q_evt)    shadow <= 1'b0;

      if (accept_asleep) sleeping <= 1'b0;
      else if (q_sleep && !acc_awake && !start_ret) sleeping <= 1'b1;
    end
  end

  // R7: the boundary after an enable strobe never accepts
  p_sei_defers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_sei |=> !acc_awake);
  // R8: once disabled, the next cycle cannot accept
  p_cli_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cli |=> !accept);
  // R4: acceptance turns the enable off
  p_ack_clears_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie);
  // R5: a wake acceptance leaves sleep
  p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_asleep |=> !sleeping);
endmodule

// File: rtl/irq_stepper.sv
module irq_stepper
  import irq_seq_pkg::*;
#(
  parameter int               PC_W     = 22,
  parameter int               SP_W     = 16,
  parameter logic [SP_W-1:0]  SP_RESET = 16'h21FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            accept_asleep,
  input  logic            start_ret,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [PC_W-1:0] vector,
  input  logic [7:0]      stk_rdata,
  output logic            idle,
  output logic            ret_done,
  output logic [SP_W-1:0] sp,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SP_W-1:0] stk_addr,
  output logic [7:0]      stk_wdata,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_load_val
);
  localparam int PC_BYTES = (PC_W + 7) / 8;
  localparam int PX       = 8 * PC_BYTES;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] WAKE_LAST = STEP_W'(WAKE_LEN - 1);
  localparam logic [STEP_W-1:0] NBYTES    = STEP_W'(PC_BYTES);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [PX-1:0]     pc_hold;
  logic [PX-1:0]     ret_buf;
  logic [PC_W-1:0]   vec_hold;

  assign idle     = (state == SQ_IDLE);
  assign stk_we   = (state == SQ_PUSH) && (step < NBYTES);
  assign stk_re   = (state == SQ_POP)  && (step < NBYTES);
  assign stk_addr = (state == SQ_POP) ? sp + SP_W'(1) : sp;
  assign pc_load  = ((state == SQ_PUSH) || (state == SQ_POP)) && (step == LAST_STEP);
  assign ret_done = (state == SQ_POP) && (step == LAST_STEP);
  assign pc_load_val = (state == SQ_POP) ? ret_buf[PC_W-1:0] : vec_hold;

  always_comb begin
    stk_wdata = '0;
    for (int b = 0; b < PC_BYTES; b++)
      if (step == STEP_W'(b)) stk_wdata = pc_hold[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      step     <= '0;
      sp       <= SP_RESET;
      pc_hold  <= '0;
      ret_buf  <= '0;
      vec_hold <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          step <= '0;
          if (accept) begin
            pc_hold  <= PX'(pc_cur);
            vec_hold <= vector;
            state    <= accept_asleep ? SQ_WAKE : SQ_PUSH;
          end else if (start_ret) begin
            state <= SQ_POP;
          end
        end
        SQ_WAKE: begin
          if (step == WAKE_LAST) begin
            step  <= '0;
            state <= SQ_PUSH;
          end else step <= step + STEP_W'(1);
        end
        SQ_PUSH: begin
          if (stk_we) sp <= sp - SP_W'(1);
          if (step == LAST_STEP) begin
            step  <= '0;
            state <= SQ_IDLE;
          end else step <= step + STEP_W'(1);
        end
        SQ_POP: begin
          if (stk_re) sp <= sp + SP_W'(1);
          for (int b = 0; b < PC_BYTES; b++)
            if (step == STEP_W'(PC_BYTES - b)) ret_buf[8*b +: 8] <= stk_rdata;
          if (step == LAST_STEP) begin
            step  <= '0;
            state <= SQ_IDLE;
          end else step <= step + STEP_W'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R3: each save moves the pointer down by one
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> sp == $past(sp) - SP_W'(1));
  // R6: each restore moves the pointer up by one
  p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re |=> sp == $past(sp) + SP_W'(1));
  // R4: a load is a single-cycle pulse
  p_load_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R9: no stack traffic or load while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !stk_we && !stk_re && !pc_load);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int               NUM_IRQ  = 8,
  parameter int               PC_W     = 22,
  parameter int               SP_W     = 16,
  parameter logic [SP_W-1:0]  SP_RESET = 16'h21FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               insn_boundary,
  input  logic               sei_strobe,
  input  logic               cli_strobe,
  input  logic               reti_strobe,
  input  logic               sleep_strobe,
  input  logic               wake,
  input  logic [PC_W-1:0]    pc_cur,
  output logic [NUM_IRQ-1:0] irq_ack,
  output logic               gie,
  output logic               sleeping,
  output logic               busy,
  output logic [SP_W-1:0]    sp,
  output logic               stk_we,
  output logic               stk_re,
  output logic [SP_W-1:0]    stk_addr,
  output logic [7:0]         stk_wdata,
  input  logic [7:0]         stk_rdata,
  output logic               pc_load,
  output logic [PC_W-1:0]    pc_load_val
);
  localparam int IW = $clog2(NUM_IRQ);

  logic               any_pend, accept, accept_asleep, start_ret, idle, ret_done;
  logic [IW-1:0]      pick_idx;
  logic [NUM_IRQ-1:0] pick_oh;
  logic [PC_W-1:0]    vector;

  irq_pick #(.N(NUM_IRQ), .IW(IW)) u_pick (
    .req(irq_req), .any(any_pend), .idx(pick_idx), .onehot(pick_oh)
  );

  assign vector = PC_W'({pick_idx, 1'b0});

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .boundary(insn_boundary),
    .sei_s(sei_strobe), .cli_s(cli_strobe), .reti_s(reti_strobe),
    .sleep_s(sleep_strobe), .wake(wake), .any_pend(any_pend),
    .idle(idle), .ret_done(ret_done), .gie(gie), .sleeping(sleeping),
    .accept(accept), .accept_asleep(accept_asleep), .start_ret(start_ret)
  );

  irq_stepper #(.PC_W(PC_W), .SP_W(SP_W), .SP_RESET(SP_RESET)) u_step (
    .clk(clk), .rst_n(rst_n), .accept(accept), .accept_asleep(accept_asleep),
    .start_ret(start_ret), .pc_cur(pc_cur), .vector(vector),
    .stk_rdata(stk_rdata), .idle(idle), .ret_done(ret_done), .sp(sp),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .pc_load(pc_load), .pc_load_val(pc_load_val)
  );

  assign irq_ack = accept ? pick_oh : '0;
  assign busy    = ~idle;

  // R2: at most one request acknowledged at a time
  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));
  // R6: a completed return re-enables interrupts
  p_ret_sets_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |=> gie);
  // R4: after acknowledge the sequencer is busy
  p_ack_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> busy);
endmodule

// File: tb/test_irq_sequencer.sv
module test_irq_sequencer;
  localparam int N = 8, PC_W = 22, SP_W = 16;
  localparam logic [15:0] SP_RST = 16'h21FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic bnd = 0, sei_s = 0, cli_s = 0, reti_s = 0, sleep_s = 0, wake = 0;
  logic [PC_W-1:0] pc_cur = 22'h3A5C10;
  logic [N-1:0] irq_ack;
  logic gie, sleeping, busy, stk_we, stk_re, pc_load;
  logic [SP_W-1:0] sp, stk_addr;
  logic [7:0] stk_wdata, stk_rdata = 8'h00;
  logic [PC_W-1:0] pc_load_val;

  always #2 clk = ~clk;

  irq_sequencer i_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .insn_boundary(bnd),
    .sei_strobe(sei_s), .cli_strobe(cli_s), .reti_strobe(reti_s),
    .sleep_strobe(sleep_s), .wake(wake), .pc_cur(pc_cur), .irq_ack(irq_ack),
    .gie(gie), .sleeping(sleeping), .busy(busy), .sp(sp), .stk_we(stk_we),
    .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .stk_rdata(stk_rdata), .pc_load(pc_load), .pc_load_val(pc_load_val)
  );

  int n_chk = 0, n_fail = 0, ack_cnt = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // stack memory: one-cycle read latency
  logic [7:0] smem [int];
  always @(posedge clk) begin
    if (stk_re) stk_rdata <= smem.exists(int'(stk_addr)) ? smem[int'(stk_addr)] : 8'h00;
    if (stk_we) smem[int'(stk_addr)] = stk_wdata;
  end

  always @(negedge clk) if (rst_n && |irq_ack) ack_cnt++;

  // behavioural reference model, evaluated mid-cycle
  int  m_mode = 0, m_k = 0, m_sp = int'(SP_RST), cyc = 0, acc_cyc = 0, ret_cyc = 0;
  bit  m_gie = 0, m_shadow = 0, m_sleep = 0, m_slept = 0;
  int  m_pc = 0, m_vec = 0;
  int  frames[$];

  always @(negedge clk) begin
    if (rst_n) begin
      int e_ack, e_addr, e_wd, e_val, off, idx;
      bit e_we, e_re, e_load, acc, awake, ret, q;
      e_ack = 0; e_addr = 0; e_wd = 0; e_val = 0; idx = 0;
      e_we = 0; e_re = 0; e_load = 0; acc = 0; awake = 0; ret = 0; q = 0;
      if (m_mode == 0) begin
        q = bnd && !m_sleep;
        if (q && m_gie && !m_shadow && !sei_s && !cli_s && !reti_s && req != 0) begin acc = 1; awake = 1; end
        if (m_sleep && wake && m_gie && req != 0) acc = 1;
        if (acc) begin
          for (int i = N-1; i >= 0; i--) if (req[i]) idx = i;
          e_ack = 1 << idx;
        end
        ret = q && reti_s;
      end else if (m_mode == 1) begin
        off = m_k - (m_slept ? 5 : 0);
        if (off >= 0 && off < 3) begin e_we = 1; e_addr = m_sp; e_wd = (m_pc >> (8*off)) & 255; end
        if (off == 4) begin e_load = 1; e_val = m_vec; end
      end else begin
        if (m_k < 3) begin e_re = 1; e_addr = (m_sp + 1) & 16'hFFFF; end
        if (m_k == 4) begin e_load = 1; e_val = frames[$]; end
      end
      chk("R2", "irq_ack", irq_ack, e_ack);
      chk("R9", "busy", busy, m_mode != 0);
      chk("R4", "gie", gie, m_gie);
      chk("R5", "sleeping", sleeping, m_sleep);
      chk("R3", "sp", sp, m_sp);
      chk("R3", "stk_we", stk_we, e_we);
      chk("R6", "stk_re", stk_re, e_re);
      if (e_we || e_re) chk("R3", "stk_addr", stk_addr, e_addr);
      if (e_we) chk("R3", "stk_wdata", stk_wdata, e_wd);
      chk("R4", "pc_load", pc_load, e_load);
      if (e_load) chk("R4", "pc_load_val", pc_load_val, e_val);
      // advance model to the next cycle
      if (m_mode == 0) begin
        if (acc) begin
          m_pc = int'(pc_cur); frames.push_back(m_pc); m_vec = idx * 2;
          m_slept = !awake; m_gie = 0; m_sleep = 0; m_mode = 1; m_k = 0; acc_cyc = cyc;
        end else if (ret) begin
          m_mode = 2; m_k = 0; ret_cyc = cyc;
        end else if (q) begin
          if (cli_s) m_gie = 0; else if (sei_s) m_gie = 1;
          m_shadow = sei_s;
          if (sleep_s) m_sleep = 1;
        end
      end else if (m_mode == 1) begin
        if (e_we) m_sp = m_sp - 1;
        if (e_load) begin
          chk(m_slept ? "R5" : "R4", "entry latency", cyc - acc_cyc, m_slept ? 10 : 5);
          m_mode = 0;
        end else m_k++;
      end else begin
        if (e_re) m_sp = m_sp + 1;
        if (e_load) begin
          chk("R6", "return latency", cyc - ret_cyc, 5);
          void'(frames.pop_back()); m_gie = 1; m_shadow = 1; m_mode = 0;
        end else m_k++;
      end
      cyc++;
    end
  end

  task automatic tick; @(posedge clk); #1; endtask
  task automatic wait_idle; while (busy) tick(); endtask

  task automatic insn(input int len, input bit s, input bit c, input bit r, input bit sl);
    wait_idle();
    for (int i = 0; i < len; i++) begin
      tick();
      bnd = (i == len-1);
      sei_s = s && bnd; cli_s = c && bnd; reti_s = r && bnd; sleep_s = sl && bnd;
    end
    tick();
    bnd = 0; sei_s = 0; cli_s = 0; reti_s = 0; sleep_s = 0;
    pc_cur = pc_cur + 22'd2;
  endtask

  initial begin
    int a0;
    repeat (3) tick();
    chk("R1", "reset gie", gie, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset sp", sp, SP_RST);
    chk("R1", "reset sleeping", sleeping, 0);
    chk("R1", "reset pc_load", pc_load, 0);
    rst_n = 1;
    tick();
    // requests with interrupts disabled are not taken
    req = 8'b0010_1000;
    repeat (3) insn(1, 0, 0, 0, 0);
    chk("R2", "no ack while disabled", ack_cnt, 0);
    // enable: the following instruction still runs
    insn(1, 1, 0, 0, 0);
    insn(1, 0, 0, 0, 0);
    chk("R7", "no ack right after enable", ack_cnt, 0);
    insn(1, 0, 0, 0, 0);
    wait_idle();
    chk("R2", "lowest request taken", ack_cnt, 1);
    chk("R3", "sp after entry", sp, SP_RST - 3);
    req[3] = 0;
    insn(2, 0, 0, 0, 0);
    insn(3, 0, 0, 1, 0);
    wait_idle();
    chk("R6", "sp after return", sp, SP_RST);
    chk("R6", "gie after return", gie, 1);
    // one instruction executes before the still pending request
    insn(1, 0, 0, 0, 0);
    chk("R7", "no ack after return", ack_cnt, 1);
    insn(1, 0, 0, 0, 0);
    wait_idle();
    chk("R2", "second request taken", ack_cnt, 2);
    req[5] = 0;
    insn(1, 0, 0, 1, 0);
    wait_idle();
    // multi-cycle instruction: request waits for the boundary
    insn(1, 0, 0, 0, 0);
    wait_idle();
    tick(); req = 8'b1000_0000; bnd = 0;
    tick(); tick();
    chk("R2", "no ack mid instruction", ack_cnt, 2);
    bnd = 1; tick(); bnd = 0;
    chk("R2", "ack at boundary", ack_cnt, 3);
    // strobes during entry are ignored
    bnd = 1; sei_s = 1; reti_s = 1; tick(); tick();
    bnd = 0; sei_s = 0; reti_s = 0;
    wait_idle();
    chk("R9", "gie unchanged by busy strobes", gie, 0);
    chk("R9", "sp after ignored strobes", sp, SP_RST - 3);
    req = 0;
    insn(1, 0, 0, 1, 0);
    wait_idle();
    // disable blocks acceptance at its own boundary
    insn(1, 0, 0, 0, 0);
    a0 = ack_cnt;
    req = 8'b0000_0100;
    insn(1, 0, 1, 0, 0);
    chk("R8", "no ack at disable", ack_cnt, a0);
    chk("R8", "gie off after disable", gie, 0);
    // sleep with enable set, wake later
    insn(1, 1, 0, 0, 0);
    req = 0;
    insn(1, 0, 0, 0, 0);
    insn(1, 0, 0, 0, 1);
    chk("R5", "sleeping set", sleeping, 1);
    req = 8'b0000_0010;
    repeat (6) tick();
    chk("R5", "no ack without wake", ack_cnt, a0);
    wake = 1; tick(); wake = 0;
    chk("R5", "ack on wake", ack_cnt, a0 + 1);
    wait_idle();
    chk("R5", "sleep left", sleeping, 0);
    req = 0;
    insn(1, 0, 0, 1, 0);
    wait_idle();
    // enable followed by sleep: sleep wins over the pending request
    insn(1, 0, 1, 0, 0);
    req = 8'b0001_0000;
    insn(1, 1, 0, 0, 0);
    insn(1, 0, 0, 0, 1);
    chk("R7", "sleep before pending request", sleeping, 1);
    chk("R7", "no ack before sleep", ack_cnt, a0 + 1);
    repeat (2) tick();
    wake = 1; tick(); wake = 0;
    wait_idle();
    chk("R5", "wake entry taken", ack_cnt, a0 + 2);
    req = 0;
    insn(1, 0, 0, 1, 0);
    wait_idle();
    chk("R6", "final sp", sp, SP_RST);
    repeat (3) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule